// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address for each beat of one SDRAM read or write burst. A column command presents a 9-bit start column, a 3-bit burst-length code and an ordering select on `cmd_i`. From the following cycle the block emits one column per clock on `col_o` with `valid_o` high. It stops when the programmed length is used up, when `stop_i` arrives, or when a new column command replaces the burst.

In sequential order the low bits of the column count upward and wrap inside the aligned window of the burst length, while the upper bits are held. In interleaved order the low bits are the start column XORed with the beat index. Full-page mode walks through all 512 columns, wraps from 511 to 0 and keeps running until it is stopped or replaced. `last_o` marks the final beat of a finite burst.

Top module: `burst_col_gen`

## Requirements
- R1: While `rst_ni` is low and after it is released with no command, `valid_o` and `last_o` are 0.
- R2: An accepted command (`cmd_i` high) makes `valid_o` 1 on the next cycle with `col_o` equal to `start_col_i` (beat 0). The length codes on `bl_code_i` are 3'b000 for 1 beat, 3'b001 for 2, 3'b010 for 4, 3'b011 for 8 and 3'b111 for full page. `il_mode_i`=1 selects interleaved order and 0 selects sequential order.
- R3: For a finite sequential burst of length BL=2^k, beat n outputs the start column's bits [8:k] unchanged and its low k bits as (start low bits + n) mod BL. Exactly BL beats are valid.
- R4: For an interleaved burst of length BL, beat n outputs the start column with its low log2(BL) bits XORed with n. Exactly BL beats are valid.
- R5: `last_o` is 1 exactly on beat BL-1 of a finite burst. `valid_o` is 0 on the next cycle unless a new command was accepted.
- R6: A full-page burst outputs (start + n) mod 512 on beat n and never raises `last_o`. It runs until it is stopped or replaced.
- R7: `stop_i` makes `valid_o` 0 from the next cycle. If an accepted command arrives in the same cycle, the command wins.
- R8: A command accepted during a running burst abandons that burst, and beat 0 of the new burst appears on the next cycle.
- R9: A command with a reserved length code (3'b100, 3'b101, 3'b110), or with full page and interleaved order together, is ignored. A running burst continues unchanged and an idle block stays idle.
- R10: Commands may arrive on consecutive cycles. Each accepted one produces its own beat 0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 1 | Column command (read or write) start |
| start_col_i | input | 9 | Start column of the command |
| bl_code_i | input | 3 | Burst length code |
| il_mode_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | Burst stop |
| col_o | output | 9 | Current column |
| valid_o | output | 1 | `col_o` holds a burst beat |
| last_o | output | 1 | Final beat of a finite burst |

## Verification
The assertions take the inputs to be plain two-state levels that are sampled only at rising edges. They allow any mix of commands, stops and rejected codes in the same cycle, but they assume that the column width is at least four bits. The stimulus drives every input at the falling edge. It draws length codes from the full 3-bit range, so reserved codes and the full-page interleaved combination appear among the legal ones, and it overlaps commands and stops at random. Directed runs cover the 511-to-0 wrap, back-to-back commands and command-with-stop collisions.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  typedef enum logic [2:0] {
    BL_ONE  = 3'b000,
    BL_TWO  = 3'b001,
    BL_FOUR = 3'b010,
    BL_EIGHT= 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;
endpackage

// File: rtl/burst_cfg_decode.sv
module burst_cfg_decode
  import burst_col_pkg::*;
#(
  parameter int COL_W = 9
) (
  input  logic [2:0]       code_i,
  input  logic             il_i,
  output logic             ok_o,
  output logic             full_o,
  output logic [COL_W-1:0] mask_o
);
  logic legal;
  always_comb begin
    legal  = 1'b1;
    full_o = 1'b0;
    mask_o = '0;
    case (bl_code_e'(code_i))
      BL_ONE:   mask_o = '0;
      BL_TWO:   mask_o = COL_W'(1);
      BL_FOUR:  mask_o = COL_W'(3);
      BL_EIGHT: mask_o = COL_W'(7);
      BL_PAGE: begin
        full_o = 1'b1;
        mask_o = '1;
      end
      default:  legal = 1'b0;
    endcase
    // full page exists only for sequential order
    ok_o = legal & ~(il_i & full_o);
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             il_i,
  output logic             act_o,
  output logic [COL_W-1:0] start_col_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             il_o,
  output logic             last_o
);
  logic full_q;

  assign last_o = act_o & ~full_q & (beat_o == mask_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_o       <= 1'b0;
      start_col_o <= '0;
      beat_o      <= '0;
      mask_o      <= '0;
      full_q      <= 1'b0;
      il_o        <= 1'b0;
    end else if (load_i) begin
      act_o       <= 1'b1;
      start_col_o <= start_col_i;
      beat_o      <= '0;
      mask_o      <= mask_i;
      full_q      <= full_i;
      il_o        <= il_i;
    end else if (stop_i || last_o) begin
      act_o       <= 1'b0;
    end else if (act_o) begin
      beat_o      <= beat_o + 1'b1; // wraps at 2^COL_W in full page
    end
  end
endmodule

// File: rtl/burst_col_map.sv
module burst_col_map #(
  parameter int COL_W = 9
) (
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] sum;
  assign sum = start_col_i + beat_i;
  always_comb begin
    if (il_i) col_o = start_col_i ^ (beat_i & mask_i);
    else      col_o = (start_col_i & ~mask_i) | (sum & mask_i);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             il_mode_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  logic             cfg_ok, cfg_full;
  logic [COL_W-1:0] cfg_mask;
  logic [COL_W-1:0] st_col, beat, mask_q;
  logic             il_q;

  burst_cfg_decode #(.COL_W(COL_W)) u_dec (
    .code_i (bl_code_i),
    .il_i   (il_mode_i),
    .ok_o   (cfg_ok),
    .full_o (cfg_full),
    .mask_o (cfg_mask)
  );

  burst_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (cmd_i & cfg_ok),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .mask_i      (cfg_mask),
    .full_i      (cfg_full),
    .il_i        (il_mode_i),
    .act_o       (valid_o),
    .start_col_o (st_col),
    .beat_o      (beat),
    .mask_o      (mask_q),
    .il_o        (il_q),
    .last_o      (last_o)
  );

  burst_col_map #(.COL_W(COL_W)) u_map (
    .start_col_i (st_col),
    .beat_i      (beat),
    .mask_i      (mask_q),
    .il_i        (il_q),
    .col_o       (col_o)
  );
endmodule

// File: rtl/burst_col_gen_chk.sv
module burst_col_gen_chk #(
  parameter int COL_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       bl_code_i,
  input logic             il_mode_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  logic acc, fp, seen;
  assign acc = cmd_i & ((bl_code_i[2] == 1'b0) | (bl_code_i == 3'b111))
                     & ~(il_mode_i & (bl_code_i == 3'b111));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fp   <= 1'b0;
      seen <= 1'b0;
    end else begin
      seen <= 1'b1;
      if (acc) fp <= (bl_code_i == 3'b111);
    end
  end

  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> valid_o && col_o == $past(start_col_i)); // R2
  AST_STOP_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !acc |=> !valid_o); // R7
  AST_LAST_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o && !acc |=> !valid_o); // R5
  AST_LAST_IN_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o); // R5
  AST_PAGE_NO_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp && valid_o |-> !last_o); // R6
  AST_UPPER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && valid_o && !fp && $past(valid_o && !acc)
      |-> col_o[COL_W-1:3] == $past(col_o[COL_W-1:3])); // R3
  AST_PAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen && valid_o && fp && $past(valid_o && !acc)
      |-> col_o == COL_W'($past(col_o) + 1'b1)); // R6
endmodule

bind burst_col_gen burst_col_gen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/tb_burst_col_gen.sv
`timescale 1ns/1ps
module tb_burst_col_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cmd_i = 1'b0;
  logic [8:0] start_col_i = '0;
  logic [2:0] bl_code_i = '0;
  logic       il_mode_i = 1'b0;
  logic       stop_i = 1'b0;
  logic [8:0] col_o;
  logic       valid_o, last_o;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  bit      m_act = 0;
  int      m_start = 0, m_beat = 0, m_bl = 1;
  bit      m_il = 0;

  always #2.5 clk_i = ~clk_i;

  burst_col_gen dut (.*);

  function automatic int code_len(input logic [2:0] c);
    case (c)
      3'b000: return 1;
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return 8;
      3'b111: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic bit accepted(input logic [2:0] c, input bit il);
    int l = code_len(c);
    return (l > 0) || (l == 0 && !il);
  endfunction

  function automatic int exp_col();
    if (m_bl == 0) return (m_start + m_beat) % 512;
    if (m_il) return m_start ^ m_beat;
    return (m_start & ~(m_bl - 1)) | ((m_start + m_beat) & (m_bl - 1));
  endfunction

  function automatic bit exp_last();
    return m_act && m_bl != 0 && m_beat == m_bl - 1;
  endfunction

  task automatic check(input string tag);
    bit e_last = exp_last();
    int e_col  = exp_col();
    n_run++;
    if (valid_o !== m_act || last_o !== e_last ||
        (m_act && int'(col_o) != e_col)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b/%0b last=%0b/%0b col=%0h/%0h (actual/expected)",
               tag, valid_o, m_act, last_o, e_last, col_o, e_col);
    end
  endtask

  task automatic step(input bit st, input int sc, input logic [2:0] cd,
                      input bit il, input bit sp, input string tag);
    cmd_i = st; start_col_i = 9'(sc); bl_code_i = cd; il_mode_i = il; stop_i = sp;
    @(posedge clk_i);
    if (st && accepted(cd, il)) begin
      m_act = 1; m_start = sc; m_beat = 0; m_bl = code_len(cd); m_il = il;
    end else if (sp || exp_last()) begin
      m_act = 0;
    end else if (m_act) begin
      m_beat = (m_beat + 1) % 512;
    end
    @(negedge clk_i);
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 3'b000, 0, 0, tag);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #12;
    check("R1");
    @(negedge clk_i); rst_ni = 1'b1;
    idle(2, "R1");
    // R2 R3: sequential 8 from mid-window
    step(1, 'h1D5, 3'b011, 0, 0, "R2");
    idle(8, "R3");
    step(1, 'h0A2, 3'b010, 0, 0, "R2");
    idle(4, "R3");
    step(1, 'h033, 3'b001, 0, 0, "R3");
    idle(2, "R3");
    step(1, 'h100, 3'b000, 0, 0, "R5");
    idle(2, "R5");
    // R4 interleaved
    step(1, 'h0A3, 3'b011, 1, 0, "R4");
    idle(8, "R4");
    step(1, 'h1F6, 3'b010, 1, 0, "R4");
    idle(4, "R4");
    // R6 full page crossing 511 -> 0, then stop (R7)
    step(1, 'h1FC, 3'b111, 0, 0, "R6");
    idle(9, "R6");
    step(0, 0, 3'b000, 0, 1, "R7");
    idle(2, "R7");
    // R7 command and stop together: command wins
    step(1, 'h040, 3'b011, 0, 0, "R7");
    step(1, 'h123, 3'b010, 0, 1, "R7");
    idle(5, "R7");
    // R8 restart mid-burst
    step(1, 'h010, 3'b011, 0, 0, "R8");
    idle(3, "R8");
    step(1, 'h1E9, 3'b011, 1, 0, "R8");
    idle(9, "R8");
    // R9 rejected codes during a burst and while idle
    step(1, 'h088, 3'b011, 0, 0, "R9");
    step(1, 'h155, 3'b100, 0, 0, "R9");
    step(1, 'h155, 3'b111, 1, 0, "R9");
    step(1, 'h155, 3'b110, 1, 0, "R9");
    idle(6, "R9");
    step(1, 'h0FF, 3'b101, 0, 0, "R9");
    idle(2, "R9");
    // R10 back-to-back commands
    step(1, 'h001, 3'b011, 0, 0, "R10");
    step(1, 'h045, 3'b010, 1, 0, "R10");
    step(1, 'h1FF, 3'b111, 0, 0, "R10");
    step(1, 'h0C7, 3'b001, 0, 0, "R10");
    idle(3, "R10");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      bit st = ($urandom_range(0, 5) == 0);
      bit sp = ($urandom_range(0, 19) == 0);
      string tg;
      tg = m_il ? "R4" : (m_bl == 0 ? "R6" : "R3");
      step(st, $urandom_range(0, 511), 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)), sp, tg);
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule